// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block receives a 32-bit control word over a write-only, three-line serial link (data, clock and an enable strobe) and presents the decoded control fields to the rest of the chip. The three serial lines come from a slow host and are brought into the system clock domain by synchronizer chains, and their edges are detected there. While the strobe is low, every rising edge of the serial clock shifts one data bit into a staging register. The first bit lands in the most significant position. A rising edge of the strobe copies the staging register into the active register, and the field outputs are decoded from the active register.

The bit count is never checked. A burst longer than 32 bits leaves only its last 32 bits in place. A shorter burst pushes part of the previous staging contents upward. A strobe pulse with no serial clock activity after the previous pulse ended is taken as a power-down command. The block then raises a request level that stays high until a pulse with clock activity ends.

The system clock must run at least four times faster than the serial clock, which runs at up to 7 MHz. Each serial edge is seen by the block three system clocks after it reaches the pins.

Top module: `cfg_serial_port`

## Requirements
- R1: While the strobe is low, each rising serial clock edge shifts the data line into bit 0 of the staging register and moves the other bits up by one. After a 32-bit burst and a strobe pulse, the first bit sent appears at `word_o[31]` and the last at `word_o[0]`.
- R2: Serial clock edges that occur while the strobe is high neither shift data nor count as clock activity.
- R3: `word_o` changes only in response to a rising strobe edge, which copies the staging register into it. Shifting alone leaves `word_o` unchanged.
- R4: A burst of more than 32 bits keeps only the last 32 bits sent. The leading surplus bits are dropped.
- R5: A burst of n < 32 bits leaves the staging register equal to the previous staging contents shifted up by n positions, with the n new bits in the low positions.
- R6: On a falling strobe edge, `pdn_req_o` goes to 1 if no serial clock edge of either polarity occurred while the strobe was low since the previous falling strobe edge (or since reset).
- R7: On a falling strobe edge that was preceded by serial clock activity while the strobe was low, `pdn_req_o` goes to 0. `pdn_req_o` changes on no other event.
- R8: The field outputs are decoded from the active word as follows:
  - `div_off_o` = bits 7:0
  - `rx_sel_o` = bit 8 (1 = receive, 0 = transmit)
  - `pll_keep_o` = bit 9
  - `txpwr_o` = bits 12:10
  - `refsel_o` = bits 14:13
  - `dcx_mode_o` = bit 18
  - `ramp_mode_o` = bit 19
  - `afc_en_o` = bit 22
  The other bits are stored and appear only on `word_o`.
- R9: After reset, `word_o`, every field output and `pdn_req_o` are 0.
- R10: A falling serial clock edge alone, while the strobe is low, counts as clock activity for R6 and R7 but shifts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host, idles low |
| ser_dat_i | input | 1 | Serial data, changes on falling serial clock |
| ser_en_i | input | 1 | Strobe: low while shifting, rising edge loads |
| word_o | output | 32 | Active control word |
| div_off_o | output | 8 | Main divider offset field |
| rx_sel_o | output | 1 | Receive (1) / transmit (0) select |
| pll_keep_o | output | 1 | Loop stays closed during the slot |
| txpwr_o | output | 3 | Transmit power step |
| refsel_o | output | 2 | Reference ratio select |
| dcx_mode_o | output | 1 | DC extractor mode |
| ramp_mode_o | output | 1 | Transmit ramp-up mode |
| afc_en_o | output | 1 | Automatic frequency control enable |
| pdn_req_o | output | 1 | Power-down request level |

## Verification
The loader is driven with these serial patterns:
- **Exact 32-bit bursts** show the bit ordering and the field placement.
- **A 40-bit burst and an 8-bit burst** tell a keep-the-newest shift register apart from one that counts bits or clears between bursts.
- **A bare strobe pulse, clock edges sent while the strobe is high, and a lone falling clock edge while the strobe is low** separate the three ways activity can or cannot be counted toward the power-down decision.
- **A check in the middle of a burst** shows that the active word waits for the strobe.

A behavioural model that delays the pin values by the synchronizer depth is compared with the outputs on every cycle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int CFG_W      = 32;
  localparam int DIV_LSB    = 0;
  localparam int DIV_W      = 8;
  localparam int RXSEL_BIT  = 8;
  localparam int PLLK_BIT   = 9;
  localparam int PWR_LSB    = 10;
  localparam int PWR_W      = 3;
  localparam int REF_LSB    = 13;
  localparam int REF_W      = 2;
  localparam int DCX_BIT    = 18;
  localparam int RAMP_BIT   = 19;
  localparam int AFC_BIT    = 22;

  typedef struct packed {
    logic [DIV_W-1:0] div_off;
    logic             rx_sel;
    logic             pll_keep;
    logic [PWR_W-1:0] txpwr;
    logic [REF_W-1:0] refsel;
    logic             dcx_mode;
    logic             ramp_mode;
    logic             afc_en;
  } cfg_fields_t;

endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o
);

  logic [LINES-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfgp_edge.sv
module cfgp_edge #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_i,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  generate
    for (genvar l = 0; l < LINES; l++) begin : g_line
      assign rise_o[l] =  lvl_i[l] & ~prev_q[l];
      assign fall_o[l] = ~lvl_i[l] &  prev_q[l];
    end
  endgenerate

endmodule

// File: rtl/cfgp_shift.sv
module cfgp_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_lvl_i,
  input  logic         en_rise_i,
  input  logic         sck_rise_i,
  input  logic         dat_i,
  output logic [W-1:0] active_o
);

  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] active_q, active_d;
  logic         shift_en;

  assign shift_en = ~en_lvl_i & sck_rise_i;

  always_comb begin
    stage_d  = stage_q;
    active_d = active_q;
    if (shift_en)  stage_d  = {stage_q[W-2:0], dat_i};
    if (en_rise_i) active_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      stage_q  <= stage_d;
      active_q <= active_d;
    end
  end

  assign active_o = active_q;

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_lvl_i && sck_rise_i) |=> (stage_q == {$past(stage_q[W-2:0]), $past(dat_i)}));

  p_no_shift_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_lvl_i |=> $stable(stage_q));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise_i |=> (active_q == $past(stage_q)));

  p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rise_i |=> $stable(active_q));

endmodule

// File: rtl/cfgp_pdet.sv
module cfgp_pdet (
  input  logic clk,
  input  logic rst_n,
  input  logic en_lvl_i,
  input  logic en_fall_i,
  input  logic sck_edge_i,
  output logic pdn_o
);

  logic seen_q, seen_d;
  logic pdn_q, pdn_d;

  always_comb begin
    seen_d = seen_q;
    pdn_d  = pdn_q;
    if (en_fall_i) begin
      pdn_d  = ~seen_q;
      seen_d = 1'b0;
    end
    if (!en_lvl_i && sck_edge_i) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pdn_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      pdn_q  <= pdn_d;
    end
  end

  assign pdn_o = pdn_q;

  p_pd_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall_i && !seen_q) |=> pdn_q);

  p_pd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall_i && seen_q) |=> !pdn_q);

  p_pd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_fall_i |=> $stable(pdn_q));

  p_high_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lvl_i && !seen_q) |=> !seen_q);

endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic [W-1:0] word_i,
  output cfg_fields_t  fields_o
);

  logic unused_rsvd;

  always_comb begin
    fields_o.div_off   = word_i[DIV_LSB +: DIV_W];
    fields_o.rx_sel    = word_i[RXSEL_BIT];
    fields_o.pll_keep  = word_i[PLLK_BIT];
    fields_o.txpwr     = word_i[PWR_LSB +: PWR_W];
    fields_o.refsel    = word_i[REF_LSB +: REF_W];
    fields_o.dcx_mode  = word_i[DCX_BIT];
    fields_o.ramp_mode = word_i[RAMP_BIT];
    fields_o.afc_en    = word_i[AFC_BIT];
  end

  assign unused_rsvd = ^{word_i[W-1:AFC_BIT+1], word_i[AFC_BIT-1:RAMP_BIT+1],
                         word_i[DCX_BIT-1:REF_LSB+REF_W]};

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_en_i,
  output logic [CFG_W-1:0] word_o,
  output logic [DIV_W-1:0] div_off_o,
  output logic             rx_sel_o,
  output logic             pll_keep_o,
  output logic [PWR_W-1:0] txpwr_o,
  output logic [REF_W-1:0] refsel_o,
  output logic             dcx_mode_o,
  output logic             ramp_mode_o,
  output logic             afc_en_o,
  output logic             pdn_req_o
);

  localparam int IDX_SCK = 0;
  localparam int IDX_EN  = 1;
  localparam int IDX_DAT = 2;
  localparam int NLINES  = 3;
  localparam int NEDGE   = 2;

  logic [NLINES-1:0] raw, lvl;
  logic [NEDGE-1:0]  rise, fall;
  logic [CFG_W-1:0]  active;
  cfg_fields_t       fields;

  assign raw = {ser_dat_i, ser_en_i, ser_clk_i};

  cfgp_sync #(.LINES(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(lvl)
  );

  cfgp_edge #(.LINES(NEDGE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl[NEDGE-1:0]),
    .rise_o(rise), .fall_o(fall)
  );

  cfgp_shift #(.W(CFG_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_lvl_i(lvl[IDX_EN]), .en_rise_i(rise[IDX_EN]),
    .sck_rise_i(rise[IDX_SCK]), .dat_i(lvl[IDX_DAT]),
    .active_o(active)
  );

  cfgp_pdet u_pdet (
    .clk(clk), .rst_n(rst_n),
    .en_lvl_i(lvl[IDX_EN]), .en_fall_i(fall[IDX_EN]),
    .sck_edge_i(rise[IDX_SCK] | fall[IDX_SCK]),
    .pdn_o(pdn_req_o)
  );

  cfgp_decode #(.W(CFG_W)) u_dec (.word_i(active), .fields_o(fields));

  assign word_o      = active;
  assign div_off_o   = fields.div_off;
  assign rx_sel_o    = fields.rx_sel;
  assign pll_keep_o  = fields.pll_keep;
  assign txpwr_o     = fields.txpwr;
  assign refsel_o    = fields.refsel;
  assign dcx_mode_o  = fields.dcx_mode;
  assign ramp_mode_o = fields.ramp_mode;
  assign afc_en_o    = fields.afc_en;

  p_fields_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(word_o) |-> ($stable(div_off_o) && $stable(txpwr_o) && $stable(refsel_o)));

endmodule

// File: tb/sim_cfg_serial_port.sv
`timescale 1ns/1ps
module sim_cfg_serial_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic [31:0] word;
  logic [7:0]  div_off;
  logic        rx_sel, pll_keep, dcx_mode, ramp_mode, afc_en, pdn;
  logic [2:0]  txpwr;
  logic [1:0]  refsel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_en_i(ser_en), .word_o(word), .div_off_o(div_off), .rx_sel_o(rx_sel),
    .pll_keep_o(pll_keep), .txpwr_o(txpwr), .refsel_o(refsel),
    .dcx_mode_o(dcx_mode), .ramp_mode_o(ramp_mode), .afc_en_o(afc_en),
    .pdn_req_o(pdn)
  );

  // behavioural reference: pin history delayed by the synchronizer depth
  logic [2:0]  hist [$];   // {en, dat, clk}
  logic [31:0] m_stage, m_word;
  bit          m_seen, m_pdn;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b000, 3'b000, 3'b000};
      m_stage = '0; m_word = '0; m_seen = 0; m_pdn = 0;
    end else begin
      logic [2:0] a, b;
      bit nseen;
      hist.push_back({ser_en, ser_dat, ser_clk});
      a = hist[hist.size()-3];
      b = hist[hist.size()-4];
      nseen = m_seen;
      if (!a[2] && b[2]) begin m_pdn = !m_seen; nseen = 0; end
      if (!a[2] && (a[0] != b[0])) nseen = 1;
      if (a[2] && !b[2]) m_word = m_stage;
      if (!a[2] && a[0] && !b[0]) m_stage = {m_stage[30:0], a[1]};
      m_seen = nseen;
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_fields(logic [31:0] w);
    chk("R8", 64'(div_off),   64'(w[7:0]),   "div_off");
    chk("R8", 64'(rx_sel),    64'(w[8]),     "rx_sel");
    chk("R8", 64'(pll_keep),  64'(w[9]),     "pll_keep");
    chk("R8", 64'(txpwr),     64'(w[12:10]), "txpwr");
    chk("R8", 64'(refsel),    64'(w[14:13]), "refsel");
    chk("R8", 64'(dcx_mode),  64'(w[18]),    "dcx_mode");
    chk("R8", 64'(ramp_mode), 64'(w[19]),    "ramp_mode");
    chk("R8", 64'(afc_en),    64'(w[22]),    "afc_en");
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", 64'(word), 64'(m_word), "model word");
      chk("R6", 64'(pdn),  64'(m_pdn),  "model pdn");
      chk_fields(m_word);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(logic b);
    ser_dat = b; tick(4); ser_clk = 1'b1; tick(4); ser_clk = 1'b0;
  endtask

  task automatic send(logic [63:0] v, int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    tick(4);
  endtask

  task automatic pulse();
    ser_en = 1'b1; tick(6); ser_en = 1'b0; tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(4);
    chk("R9", 64'(word), 64'h0, "reset word");
    chk("R9", 64'(pdn),  64'h0, "reset pdn");
    chk_fields(32'h0);
    rst_n = 1'b1;
    tick(4);

    // R1, R8: exact 32-bit burst
    send(64'h9C6B_35A7, 32); pulse();
    chk("R1", 64'(word), 64'h9C6B_35A7, "word after 32 bits");
    chk_fields(32'h9C6B_35A7);
    chk("R7", 64'(pdn), 64'h0, "pdn after programming");

    // R6: bare pulse
    pulse();
    chk("R6", 64'(pdn), 64'h1, "pdn after bare pulse");
    chk("R3", 64'(word), 64'h9C6B_35A7, "word after bare pulse");

    // R7: programming pulse clears request
    send(64'h0041_7E2D, 32); pulse();
    chk("R7", 64'(pdn), 64'h0, "pdn after write");
    chk("R1", 64'(word), 64'h0041_7E2D, "second word");
    chk_fields(32'h0041_7E2D);

    // R4: 40-bit burst keeps last 32
    send({24'h0, 8'hFF, 32'h1234_5678}, 40); pulse();
    chk("R4", 64'(word), 64'h1234_5678, "long burst");

    // R5: 8-bit burst shifts previous contents
    send(64'hC3, 8); pulse();
    chk("R5", 64'(word), 64'h3456_78C3, "short burst");

    // R3: mid-burst the active word holds
    send(64'hDEAD, 16);
    chk("R3", 64'(word), 64'h3456_78C3, "word mid burst");
    send(64'hBEEF, 16); pulse();
    chk("R3", 64'(word), 64'hDEAD_BEEF, "word after load");
    chk_fields(32'hDEAD_BEEF);

    // R2: clock edges while strobe high are ignored
    ser_en = 1'b1; tick(4);
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    tick(4); ser_en = 1'b0; tick(6);
    chk("R2", 64'(pdn), 64'h1, "pdn with clocks only while high");
    chk("R2", 64'(word), 64'hDEAD_BEEF, "word with clocks while high");
    pulse();
    chk("R2", 64'(word), 64'hDEAD_BEEF, "no shift while high");

    // R10: lone falling clock edge while low counts as activity
    ser_en = 1'b1; tick(4); ser_clk = 1'b1; tick(4);
    ser_en = 1'b0; tick(6);
    chk("R6", 64'(pdn), 64'h1, "pdn before lone fall");
    ser_clk = 1'b0; tick(6);
    pulse();
    chk("R10", 64'(pdn), 64'h0, "pdn after lone falling edge");
    chk("R10", 64'(word), 64'hDEAD_BEEF, "lone falling edge no shift");

    tick(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule